// File: doc/BRIEF.md
# I2C Transmit Bit Timing Sequencer

This block places each transmitted data bit on an open-drain I2C data line at a controlled distance from the clock edges. It watches the bus clock level. After every falling edge it detects, it holds the clock line low, waits a programmable hold interval, then presents the next bit on the data line. It then waits a programmable setup interval, counted from the moment the bit appeared, and only then lets the clock line go. One prescaler turns the kernel clock into the time unit for both intervals. Only one interval runs at a time.

Bytes come from a valid/data pair and leave most significant bit first. If no byte is waiting when the first bit of a byte is due, the clock line stays low until one arrives. A one-cycle pulse reports that the last bit of a byte has finished, so the source can supply the next byte. Generating the clock periods, START/STOP conditions, arbitration and acknowledge handling are left to neighbouring logic. The configuration inputs must stay constant while a byte is being sent.

Top module: `i2c_bit_sequencer`

## Requirements
- R1: After reset, `sda_o` and `scl_o` are both 1 (released) and `byte_done_o` is 0.
- R2: If the bus clock `scl_i` is first sampled low at clock edge E1 after being seen high, `scl_o` goes to 0 at edge E1+SYNC_STAGES. It stays 0 until the release of R4.
- R3: With P = `presc_i` and H = `hold_i`, when data is available the new bit appears on `sda_o` at edge E1+SYNC_STAGES+1+H*(P+1). This applies for every prescaler value 0 to 15.
- R4: With S = `setup_i`, `scl_o` returns to 1 exactly (S+1)*(P+1)+1 kernel cycles after the edge at which the bit was driven on `sda_o`.
- R5: If `tx_valid_i` is 0 when the hold interval of a byte's first bit ends, `scl_o` stays 0 and `sda_o` keeps its value. The bit is driven at the first edge that samples `tx_valid_i` high, and the setup interval of R4 counts from that edge.
- R6: Bits leave most significant first, eight per byte. `tx_data_i` is captured at the edge that drives the byte's first bit. Later changes of `tx_data_i` or `tx_valid_i` do not alter the remaining seven bits.
- R7: `byte_done_o` is high for exactly one cycle, at the same edge where `scl_o` is released after the eighth bit. It is never high at any other time.
- R8: `sda_o` equals the current bit value: 0 pulls the line low and 1 releases it. The value at each clock release equals the bit being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level as seen on the wire |
| presc_i | input | 4 | Prescaler: time unit is presc_i+1 kernel cycles |
| setup_i | input | 4 | Setup count: interval is setup_i+1 units |
| hold_i | input | 4 | Hold count: interval is hold_i units |
| tx_valid_i | input | 1 | A transmit byte is available |
| tx_data_i | input | 8 | Transmit byte |
| sda_o | output | 1 | Data line drive, 0 = pull low, 1 = release |
| scl_o | output | 1 | Clock line drive, 0 = stretch low, 1 = release |
| byte_done_o | output | 1 | One-cycle pulse after the last bit of a byte |

## Verification
Bytes are sent with several prescaler, hold and setup combinations, including all-zero and all-maximum settings. This separates an error that scales with the time unit from a fixed one-cycle offset. Some bytes arrive late, after the hold interval has already ended. These show whether the setup count starts at the data edge or at the clock edge. Data patterns whose adjacent bits differ expose the drive edge of the data line. Changing `tx_data_i` in the middle of a byte shows whether the byte was captured once, when its first bit was driven.

// File: rtl/i2c_bit_seq_pkg.sv
package i2c_bit_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HOLD  = 2'd1,
      ST_WAIT  = 2'd2,
      ST_SETUP = 2'd3
   } seq_state_t;

endpackage

// File: rtl/i2c_bit_seq_sync.sv
module i2c_bit_seq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain[g] <= 1'b1;
               else         chain[g] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain[g] <= 1'b1;
               else         chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) last_q <= 1'b1;
      else         last_q <= chain[STAGES-1];
   end

   assign q_o    = chain[STAGES-1];
   assign fall_o = last_q & ~chain[STAGES-1];

endmodule

// File: rtl/i2c_bit_seq_delay.sv
module i2c_bit_seq_delay #(
   parameter int PRESC_W = 4,
   parameter int UNIT_W  = 5
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               load_i,
   input  logic [UNIT_W-1:0]  units_i,
   input  logic [PRESC_W-1:0] presc_i,
   output logic               zero_o
);
   logic [UNIT_W-1:0]  remain_q;
   logic [PRESC_W-1:0] tick_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         remain_q <= '0;
         tick_q   <= '0;
      end else if (load_i) begin
         remain_q <= units_i;
         tick_q   <= '0;
      end else if (remain_q != '0) begin
         if (tick_q == presc_i) begin
            tick_q   <= '0;
            remain_q <= remain_q - UNIT_W'(1);
         end else begin
            tick_q <= tick_q + PRESC_W'(1);
         end
      end
   end

   assign zero_o = (remain_q == '0);

   // R4: without a reload the remaining count never grows
   assert_count_monotone_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> (remain_q <= $past(remain_q)));

   // R3: a running count always reaches a unit boundary within the prescale period
   assert_tick_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && remain_q != '0 && tick_q == presc_i) |=> (tick_q == '0));

endmodule

// File: rtl/i2c_bit_seq_shifter.sv
module i2c_bit_seq_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              adv_i,
   input  logic [BYTE_W-1:0] data_i,
   output logic              bit_o,
   output logic              first_o,
   output logic              last_o
);
   localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

   logic [BYTE_W-1:0] shreg_q;
   logic [IDX_W-1:0]  idx_q;

   assign first_o = (idx_q == '0);
   assign last_o  = (idx_q == LAST_IDX);
   assign bit_o   = first_o ? data_i[BYTE_W-1] : shreg_q[BYTE_W-1];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         shreg_q <= '0;
         idx_q   <= '0;
      end else if (adv_i) begin
         shreg_q <= first_o ? (data_i << 1) : (shreg_q << 1);
         idx_q   <= last_o ? '0 : idx_q + IDX_W'(1);
      end
   end

   // R6: after the final bit the next advance starts a fresh byte
   assert_wrap_after_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_i && last_o) |=> first_o);

   // R6: the bit position only moves on an advance
   assert_idx_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !adv_i |=> $stable(idx_q));

endmodule

// File: rtl/i2c_bit_sequencer.sv
module i2c_bit_sequencer
   import i2c_bit_seq_pkg::*;
#(
   parameter int CFG_W       = 4,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              scl_i,
   input  logic [CFG_W-1:0]  presc_i,
   input  logic [CFG_W-1:0]  setup_i,
   input  logic [CFG_W-1:0]  hold_i,
   input  logic              tx_valid_i,
   input  logic [BYTE_W-1:0] tx_data_i,
   output logic              sda_o,
   output logic              scl_o,
   output logic              byte_done_o
);
   localparam int UNIT_W = CFG_W + 1;

   generate
      if (CFG_W < 1 || CFG_W > 16) begin : g_bad_cfg
         $error("CFG_W out of range");
      end
      if (BYTE_W < 2) begin : g_bad_byte
         $error("BYTE_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   seq_state_t        state_q;
   logic              scl_sync;
   logic              scl_fall;
   logic              delay_zero;
   logic              delay_load;
   logic [UNIT_W-1:0] delay_units;
   logic              cur_bit;
   logic              at_first;
   logic              at_last;
   logic              last_q;
   logic              drive_now;

   i2c_bit_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (scl_i),
      .q_o    (scl_sync),
      .fall_o (scl_fall)
   );

   i2c_bit_seq_delay #(.PRESC_W(CFG_W), .UNIT_W(UNIT_W)) u_delay (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (delay_load),
      .units_i (delay_units),
      .presc_i (presc_i),
      .zero_o  (delay_zero)
   );

   i2c_bit_seq_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .adv_i   (drive_now),
      .data_i  (tx_data_i),
      .bit_o   (cur_bit),
      .first_o (at_first),
      .last_o  (at_last)
   );

   always_comb begin
      drive_now = 1'b0;
      if (state_q == ST_HOLD && delay_zero && (!at_first || tx_valid_i))
         drive_now = 1'b1;
      else if (state_q == ST_WAIT && tx_valid_i)
         drive_now = 1'b1;
   end

   always_comb begin
      delay_load  = 1'b0;
      delay_units = '0;
      if (state_q == ST_IDLE && scl_fall) begin
         delay_load  = 1'b1;
         delay_units = {1'b0, hold_i};
      end else if (drive_now) begin
         delay_load  = 1'b1;
         delay_units = {1'b0, setup_i} + UNIT_W'(1);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q     <= ST_IDLE;
         scl_o       <= 1'b1;
         sda_o       <= 1'b1;
         byte_done_o <= 1'b0;
         last_q      <= 1'b0;
      end else begin
         byte_done_o <= 1'b0;
         if (drive_now) begin
            sda_o   <= cur_bit;
            last_q  <= at_last;
            state_q <= ST_SETUP;
         end else begin
            case (state_q)
               ST_IDLE: begin
                  if (scl_fall) begin
                     scl_o   <= 1'b0;
                     state_q <= ST_HOLD;
                  end
               end
               ST_HOLD: begin
                  if (delay_zero) state_q <= ST_WAIT;
               end
               ST_WAIT: begin
                  state_q <= ST_WAIT;
               end
               ST_SETUP: begin
                  if (delay_zero) begin
                     scl_o       <= 1'b1;
                     byte_done_o <= last_q;
                     state_q     <= ST_IDLE;
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   // R3: the data line only moves when a hold or wait phase hands over a bit
   assert_sda_at_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(sda_o) |-> ($past(state_q) == ST_HOLD || $past(state_q) == ST_WAIT));

   // R4: the clock line is released only when a setup interval ends
   assert_release_from_setup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(scl_o) |-> ($past(state_q) == ST_SETUP));

   // R5: while waiting for data the clock stays stretched and data holds
   assert_wait_stretch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_WAIT && !tx_valid_i) |=> (!scl_o && $stable(sda_o)));

   // R2: a detected fall while idle always stretches the clock
   assert_stretch_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_IDLE && scl_fall) |=> !scl_o);

   // R7: the byte completion pulse lines up with a clock release
   assert_done_with_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byte_done_o |-> $rose(scl_o));

   // R7: the pulse is a single cycle
   assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byte_done_o |=> !byte_done_o);

endmodule

// File: tb/i2c_bit_sequencer_test.sv
module i2c_bit_sequencer_test;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC_N     = 2;

   typedef struct packed {
      logic bit_v;
      logic last;
      int   fall_e;
      int   sda_e;
      int   rel_e;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       master_scl = 1'b1;
   logic [3:0] presc = '0, setup = '0, hold = '0;
   logic       tx_valid = 1'b0;
   logic [7:0] tx_data = '0;
   logic       sda_o, scl_o, byte_done_o;
   wire        scl_bus = master_scl & scl_o;

   int   cyc = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   ended = 1'b0;
   bit   mon_en = 1'b0;
   logic prev_sda = 1'b1, prev_scl = 1'b1;
   exp_t exp_q[$];

   i2c_bit_sequencer uut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .scl_i       (scl_bus),
      .presc_i     (presc),
      .setup_i     (setup),
      .hold_i      (hold),
      .tx_valid_i  (tx_valid),
      .tx_data_i   (tx_data),
      .sda_o       (sda_o),
      .scl_o       (scl_o),
      .byte_done_o (byte_done_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (mon_en) begin
         if (prev_scl && !scl_o) begin
            if (exp_q.size() == 0) check(1'b0, "R2 unexpected stretch", cyc, -1);
            else check(cyc == exp_q[0].fall_e, "R2 stretch edge", cyc, exp_q[0].fall_e);
         end
         if (sda_o !== prev_sda) begin
            if (exp_q.size() == 0) check(1'b0, "R3 unexpected sda change", cyc, -1);
            else begin
               check(cyc == exp_q[0].sda_e, "R3/R5 sda drive edge", cyc, exp_q[0].sda_e);
               check(sda_o == exp_q[0].bit_v, "R8 sda value at drive", int'(sda_o), int'(exp_q[0].bit_v));
            end
         end
         if (!prev_scl && scl_o) begin
            if (exp_q.size() == 0) check(1'b0, "R4 unexpected release", cyc, -1);
            else begin
               check(cyc == exp_q[0].rel_e, "R4 release edge", cyc, exp_q[0].rel_e);
               check(sda_o == exp_q[0].bit_v, "R6/R8 bit at release", int'(sda_o), int'(exp_q[0].bit_v));
               check(byte_done_o == exp_q[0].last, "R7 byte_done at release",
                     int'(byte_done_o), int'(exp_q[0].last));
               void'(exp_q.pop_front());
            end
         end else if (byte_done_o) begin
            check(1'b0, "R7 byte_done without release", 1, 0);
         end
         prev_sda <= sda_o;
         prev_scl <= scl_o;
      end
   end

   // driver: one byte with given timing and data lateness
   task automatic send_byte(input int p, input int h, input int s,
                            input logic [7:0] data, input int late);
      presc   = 4'(p);
      hold    = 4'(h);
      setup   = 4'(s);
      tx_data = data;
      if (late == 0) tx_valid = 1'b1;
      for (int i = 0; i < 8; i++) begin
         int e1, ehold, sda_e;
         exp_t it;
         @(negedge clk);
         master_scl = 1'b0;
         e1    = cyc + 1;
         ehold = e1 + SYNC_N + 1 + h * (p + 1);
         sda_e = (i == 0 && late > 0) ? ehold + late : ehold;
         it.bit_v  = data[7-i];
         it.last   = (i == 7);
         it.fall_e = e1 + SYNC_N;
         it.sda_e  = sda_e;
         it.rel_e  = sda_e + (s + 1) * (p + 1) + 1;
         exp_q.push_back(it);
         if (i == 0 && late > 0) begin
            while (cyc < sda_e - 1) @(negedge clk);
            tx_valid = 1'b1;
         end
         while (scl_o !== 1'b0) @(negedge clk);
         while (scl_o !== 1'b1) @(negedge clk);
         if (i == 0) begin
            tx_valid = 1'b0;
            tx_data  = ~data;   // R6: ignored for the rest of the byte
         end
         @(negedge clk);
         master_scl = 1'b1;
         repeat (4) @(negedge clk);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(sda_o == 1'b1, "R1 sda reset", int'(sda_o), 1);
      check(scl_o == 1'b1, "R1 scl reset", int'(scl_o), 1);
      check(byte_done_o == 1'b0, "R1 byte_done reset", int'(byte_done_o), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      mon_en = 1'b1;
      send_byte(0, 0, 0, 8'hA5, 0);
      send_byte(1, 3, 2, 8'h3C, 0);
      send_byte(3, 5, 1, 8'hC3, 4);   // R5 late data
      send_byte(15, 2, 3, 8'h96, 0);
      send_byte(0, 15, 15, 8'h5A, 7); // R5 late data, maximum counts
      send_byte(7, 1, 0, 8'hF0, 0);
      send_byte(15, 15, 15, 8'h0F, 2);
      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "R7 all bits released", exp_q.size(), 0);
      check(scl_o == 1'b1, "R4 idle released", int'(scl_o), 1);
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected 0 (run did not finish)", cyc);
      finish_run();
   end

endmodule